// File: doc/BRIEF.md
# Segment Selector Translator

This block turns a logical address into a 32-bit linear address. A logical address has two parts: a 16-bit selector held in one of several segment registers, and a 32-bit offset that comes with each access. Software first programs a base and a byte limit for two descriptor tables, one global and one local. A load request then names a segment register and a selector. The block fetches the selector's 8-byte descriptor over a read-only memory port as two 32-bit words. It decodes the base, the 20-bit limit, the granularity bit, the privilege level, the present bit and the accessed bit, and keeps them in a hidden copy next to the visible selector.

Accesses never touch memory. An access names a segment register, an offset and a size of one to four bytes. The block checks the access against the cached limit, reports a fault code, and adds the cached base to produce the linear address in the same cycle. If a load fails, either because the entry lies outside its table or because the present bit is clear, the block reports a fault and leaves the hidden copy untouched. A null selector loads without a memory read and makes the register unusable until it is loaded again.

Top module: `seg_xlate`

## Requirements
- R1: The selector is split into three fields. Bits 15:3 are the entry index. Bit 2 picks the table: 0 for the global table, 1 for the local table. Bits 1:0 are the requested privilege level. The level of the selected register's loaded selector appears on `acc_rpl`.
- R2: A load reads the descriptor word at table base + index*8 first and the word at +4 second. Each read is a request held stable on the valid/ready port until it is accepted, and each accepted request is answered by exactly one response word.
- R3: The descriptor's fields sit at fixed positions. The low word holds limit[15:0] in bits 15:0 and base[15:0] in bits 31:16. The high word holds base[23:16] in bits 7:0, the accessed bit in bit 8, the privilege level in bits 14:13, the present bit in bit 15, limit[19:16] in bits 19:16, granularity in bit 23 and base[31:24] in bits 31:24.
- R4: A load whose entry end (index*8+7) exceeds the selected table limit finishes with `ld_fault_code` 1. It issues no memory read and leaves the target register unchanged. An entry that ends exactly at the limit loads normally.
- R5: A load whose descriptor has the present bit clear finishes with `ld_fault_code` 2 and leaves the target register unchanged.
- R6: A selector with index 0 and table bit 0 loads without any memory read and with `ld_fault_code` 0, but marks the register unusable. Every register is unusable after reset. Any access through an unusable register reports `acc_fault_code` 2.
- R7: With granularity clear, an access reports `acc_fault_code` 1 when offset + `acc_len_m1` exceeds the 20-bit limit. Otherwise it reports 0.
- R8: With granularity set, the effective limit is the limit followed by twelve one bits, and the same check as R7 applies against it. The check uses 33-bit arithmetic, so the end of an access never wraps.
- R9: `lin_addr` is the cached base plus the offset, modulo 2^32.
- R10: `busy` rises in the cycle after an accepted load that needs memory, and falls at the edge that completes it. `ld_valid` is ignored while `busy` is high. `ld_done` pulses for one cycle after every accepted load completes.
- R11: A load copies the descriptor's accessed bit into the cached copy, which is shown on `acc_accessed`. An `acc_valid` pulse whose access has `acc_fault_code` 0 sets that bit. A faulting access does not set it.
- R12: `acc_dpl` shows the cached descriptor privilege level of the selected register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gdt_base | input | 32 | Global table base address |
| gdt_limit | input | 16 | Global table byte limit |
| ldt_base | input | 32 | Local table base address |
| ldt_limit | input | 16 | Local table byte limit |
| ld_valid | input | 1 | Load request |
| ld_seg | input | SW | Segment register to load |
| ld_sel | input | 16 | Selector to load |
| busy | output | 1 | Descriptor fetch in progress |
| ld_done | output | 1 | One-cycle load completion pulse |
| ld_fault_code | output | 2 | Load result: 0 ok, 1 outside table, 2 not present |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Memory read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| acc_seg | input | SW | Segment register used by the access |
| acc_off | input | 32 | Access offset |
| acc_len_m1 | input | 2 | Access size in bytes minus one |
| acc_valid | input | 1 | Access takes place (sets accessed bit) |
| lin_addr | output | 32 | Linear address |
| acc_fault_code | output | 2 | Access result: 0 ok, 1 limit, 2 unusable |
| acc_dpl | output | 2 | Cached descriptor privilege level |
| acc_rpl | output | 2 | Requested privilege level of the loaded selector |
| acc_accessed | output | 1 | Cached accessed bit |

## Verification
The assertions rely on the memory side to behave. It may raise `mem_rsp_valid` only for a request it has already accepted, and only once for each such request. The table base and limit inputs must also stay steady while `busy` is high. The bench's memory model answers exactly one cycle after each accepted request and drives ready in an irregular pattern. The bench changes table settings only between loads. It probes accesses at the limit edges, one byte either side, and across the 4 GiB wrap of the base addition.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int NSEG = 4,
  localparam int SW = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   gdt_base,
  input  logic [15:0]   gdt_limit,
  input  logic [31:0]   ldt_base,
  input  logic [15:0]   ldt_limit,
  input  logic          ld_valid,
  input  logic [SW-1:0] ld_seg,
  input  logic [15:0]   ld_sel,
  output logic          busy,
  output logic          ld_done,
  output logic [1:0]    ld_fault_code,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [31:0]   mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [31:0]   mem_rsp_data,
  input  logic [SW-1:0] acc_seg,
  input  logic [31:0]   acc_off,
  input  logic [1:0]    acc_len_m1,
  input  logic          acc_valid,
  output logic [31:0]   lin_addr,
  output logic [1:0]    acc_fault_code,
  output logic [1:0]    acc_dpl,
  output logic [1:0]    acc_rpl,
  output logic          acc_accessed
);

  typedef enum logic [2:0] {S_IDLE, S_REQ0, S_RSP0, S_REQ1, S_RSP1} st_t;
  st_t st;

  logic [15:0]   c_sel  [NSEG];
  logic [31:0]   c_base [NSEG];
  logic [19:0]   c_lim  [NSEG];
  logic          c_g    [NSEG];
  logic [1:0]    c_dpl  [NSEG];
  logic          c_acc  [NSEG];
  logic          c_ok   [NSEG];

  logic [SW-1:0] tgt_seg;
  logic [15:0]   tgt_sel;
  logic [31:0]   dsc_addr;
  logic [31:0]   w0;
  logic          done_q;
  logic [1:0]    code_q;

  wire [12:0] ld_idx   = ld_sel[15:3];
  wire        ld_ti    = ld_sel[2];
  wire [31:0] tbl_base = ld_ti ? ldt_base : gdt_base;
  wire [15:0] tbl_lim  = ld_ti ? ldt_limit : gdt_limit;
  wire        ld_null  = (ld_idx == 13'd0) && !ld_ti;
  wire        ld_over  = {ld_idx, 3'b111} > tbl_lim;

  wire unused_bits = &{1'b0, mem_rsp_data[22:20], mem_rsp_data[12], mem_rsp_data[11:9]};

  assign busy          = (st != S_IDLE);
  assign mem_req_valid = (st == S_REQ0) || (st == S_REQ1);
  assign mem_req_addr  = dsc_addr + ((st == S_REQ1) ? 32'd4 : 32'd0);
  assign ld_done       = done_q;
  assign ld_fault_code = code_q;

  wire [31:0] eff_lim = c_g[acc_seg] ? {c_lim[acc_seg], 12'hFFF} : {12'h000, c_lim[acc_seg]};
  wire [32:0] acc_end = {1'b0, acc_off} + {31'd0, acc_len_m1};

  assign acc_fault_code = !c_ok[acc_seg] ? 2'd2 : (acc_end > {1'b0, eff_lim}) ? 2'd1 : 2'd0;
  assign lin_addr       = c_base[acc_seg] + acc_off;
  assign acc_dpl        = c_dpl[acc_seg];
  assign acc_rpl        = c_sel[acc_seg][1:0];
  assign acc_accessed   = c_acc[acc_seg];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      tgt_seg  <= '0;
      tgt_sel  <= '0;
      dsc_addr <= '0;
      w0       <= '0;
      done_q   <= 1'b0;
      code_q   <= 2'd0;
      for (int i = 0; i < NSEG; i++) begin
        c_sel[i]  <= '0;
        c_base[i] <= '0;
        c_lim[i]  <= '0;
        c_g[i]    <= 1'b0;
        c_dpl[i]  <= '0;
        c_acc[i]  <= 1'b0;
        c_ok[i]   <= 1'b0;
      end
    end else begin
      done_q <= 1'b0;
      code_q <= 2'd0;
      if (acc_valid && acc_fault_code == 2'd0)
        c_acc[acc_seg] <= 1'b1;
      case (st)
        S_IDLE: if (ld_valid) begin
          if (ld_null) begin
            c_sel[ld_seg] <= ld_sel;
            c_ok[ld_seg]  <= 1'b0;
            done_q        <= 1'b1;
          end else if (ld_over) begin
            done_q <= 1'b1;
            code_q <= 2'd1;
          end else begin
            tgt_seg  <= ld_seg;
            tgt_sel  <= ld_sel;
            dsc_addr <= tbl_base + {16'd0, ld_idx, 3'b000};
            st       <= S_REQ0;
          end
        end
        S_REQ0: if (mem_req_ready) st <= S_RSP0;
        S_RSP0: if (mem_rsp_valid) begin
          w0 <= mem_rsp_data;
          st <= S_REQ1;
        end
        S_REQ1: if (mem_req_ready) st <= S_RSP1;
        S_RSP1: if (mem_rsp_valid) begin
          st     <= S_IDLE;
          done_q <= 1'b1;
          if (!mem_rsp_data[15]) begin
            code_q <= 2'd2;
          end else begin
            c_sel[tgt_seg]  <= tgt_sel;
            c_base[tgt_seg] <= {mem_rsp_data[31:24], mem_rsp_data[7:0], w0[31:16]};
            c_lim[tgt_seg]  <= {mem_rsp_data[19:16], w0[15:0]};
            c_g[tgt_seg]    <= mem_rsp_data[23];
            c_dpl[tgt_seg]  <= mem_rsp_data[14:13];
            c_acc[tgt_seg]  <= mem_rsp_data[8];
            c_ok[tgt_seg]   <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        ld_done,
  input logic [1:0]  ld_fault_code,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic [1:0]  acc_fault_code
);

  a_r10_req_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);

  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r10_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ld_done |-> !busy);

  a_r10_busy_ends_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ld_done);

  a_r4_code_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_fault_code != 2'd0) |-> ld_done);

  a_r6_acc_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fault_code != 2'd3);

endmodule

bind seg_xlate seg_xlate_chk u_seg_xlate_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ld_done(ld_done),
  .ld_fault_code(ld_fault_code), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .acc_fault_code(acc_fault_code)
);

// File: tb/test_seg_xlate.sv
`timescale 1ns/1ps
module test_seg_xlate;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] gdt_base = 32'h100, ldt_base = 32'h300;
  logic [15:0] gdt_limit = 16'h003F, ldt_limit = 16'h00FF;
  logic ld_valid = 0; logic [1:0] ld_seg = 0; logic [15:0] ld_sel = 0;
  logic busy, ld_done; logic [1:0] ld_fault_code;
  logic mem_req_valid, mem_req_ready = 0; logic [31:0] mem_req_addr;
  logic mem_rsp_valid = 0; logic [31:0] mem_rsp_data = 0;
  logic [1:0] acc_seg = 0; logic [31:0] acc_off = 0; logic [1:0] acc_len_m1 = 0;
  logic acc_valid = 0;
  logic [31:0] lin_addr; logic [1:0] acc_fault_code, acc_dpl, acc_rpl; logic acc_accessed;

  seg_xlate #(.NSEG(4)) i_seg_xlate (.*);

  logic [31:0] mem [256];
  int nreq = 0, cyc = 0;
  logic [31:0] a_prev = 0, a_last = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_req_ready <= (cyc % 3) != 1;
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= mem[mem_req_addr[9:2]];
      nreq   <= nreq + 1;
      a_prev <= a_last;
      a_last <= mem_req_addr;
    end
  end

  int vectors = 0, miscompares = 0;
  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put_desc(input logic [31:0] addr, input logic [31:0] base, input logic [19:0] lim,
                          input logic g, input logic p, input logic [1:0] dpl, input logic acc);
    mem[addr[9:2]]        = {base[15:0], lim[15:0]};
    mem[addr[9:2] + 8'd1] = {base[31:24], g, 3'b100, lim[19:16], p, dpl, 1'b1, 3'b001, acc, base[23:16]};
  endtask

  int rd; logic sb; logic [1:0] lc;
  task automatic do_load(input logic [1:0] seg, input logic [15:0] sel,
                         output int reads, output logic saw_busy, output logic [1:0] code);
    int n0;
    n0 = nreq; saw_busy = 0;
    @(negedge clk); ld_seg = seg; ld_sel = sel; ld_valid = 1;
    @(negedge clk); ld_valid = 0;
    for (int k = 0; k < 60 && !ld_done; k++) begin
      if (busy) saw_busy = 1;
      @(negedge clk);
    end
    check("R10 done pulse", ld_done, 1);
    code = ld_fault_code; reads = nreq - n0;
  endtask

  task automatic probe(input logic [1:0] seg, input logic [31:0] off, input logic [1:0] lm1);
    acc_seg = seg; acc_off = off; acc_len_m1 = lm1; #2;
  endtask

  task automatic touch(input logic [1:0] seg, input logic [31:0] off);
    @(negedge clk); acc_seg = seg; acc_off = off; acc_len_m1 = 0; acc_valid = 1;
    @(negedge clk); acc_valid = 0; #2;
  endtask

  task automatic t_reset;
    for (int s = 0; s < 4; s++) begin
      probe(s[1:0], 0, 0);
      check("R6 unusable after reset", acc_fault_code, 2);
    end
    check("R10 idle after reset", busy, 0);
  endtask

  task automatic t_global;
    do_load(2'd1, 16'h000A, rd, sb, lc);
    check("R2 code", lc, 0); check("R2 reads", rd, 2);
    check("R2 first addr", a_prev, 32'h108); check("R2 second addr", a_last, 32'h10C);
    check("R10 busy seen", sb, 1);
    probe(1, 32'h100, 0);
    check("R9 R3 lin", lin_addr, 32'h12345778); check("R7 ok", acc_fault_code, 0);
    check("R1 rpl", acc_rpl, 2); check("R12 dpl", acc_dpl, 1);
    check("R11 acc copied", acc_accessed, 0);
    probe(1, 32'hABCDE, 0); check("R3 limit edge ok", acc_fault_code, 0);
    probe(1, 32'hABCDF, 0); check("R7 limit+1 fault", acc_fault_code, 1);
    touch(1, 0); check("R11 acc set", acc_accessed, 1);
  endtask

  task automatic t_local;
    do_load(2'd0, 16'h002C, rd, sb, lc);
    check("R1 local code", lc, 0);
    check("R1 R2 local addr0", a_prev, 32'h328); check("R2 local addr1", a_last, 32'h32C);
    probe(0, 32'h10, 0);
    check("R1 local lin", lin_addr, 32'hCAFE0010); check("R12 local dpl", acc_dpl, 2);
  endtask

  task automatic t_byte_limit;
    do_load(2'd2, 16'h0010, rd, sb, lc);
    probe(2, 0, 0); check("R11 acc copied set", acc_accessed, 1);
    probe(2, 32'hFFF, 0); check("R7 last byte", acc_fault_code, 0);
    probe(2, 32'hFFE, 3); check("R7 straddle", acc_fault_code, 1);
    probe(2, 32'hFFC, 3); check("R7 dword fits", acc_fault_code, 0);
  endtask

  task automatic t_page_limit;
    do_load(2'd3, 16'h001B, rd, sb, lc);
    probe(3, 32'h2FFF, 0); check("R8 page edge", acc_fault_code, 0);
    probe(3, 32'h2FFD, 3); check("R8 straddle", acc_fault_code, 1);
    probe(3, 32'h3000, 0); check("R8 beyond", acc_fault_code, 1);
    probe(3, 32'h2000, 0); check("R9 wrap", lin_addr, 32'h00001000);
    touch(3, 32'h3000); probe(3, 0, 0); check("R11 fault no set", acc_accessed, 0);
  endtask

  task automatic t_table_limit;
    do_load(2'd1, 16'h0040, rd, sb, lc);
    check("R4 gdt over code", lc, 1); check("R4 no read", rd, 0);
    probe(1, 32'h100, 0); check("R4 unchanged", lin_addr, 32'h12345778);
    check("R4 rpl unchanged", acc_rpl, 2);
    do_load(2'd1, 16'h0104, rd, sb, lc); check("R4 ldt over code", lc, 1);
    do_load(2'd0, 16'h0038, rd, sb, lc); check("R4 end at limit", lc, 0);
    probe(0, 1, 0); check("R4 edge entry lin", lin_addr, 32'h7001);
  endtask

  task automatic t_not_present;
    do_load(2'd2, 16'h0020, rd, sb, lc);
    check("R5 code", lc, 2); check("R5 reads", rd, 2);
    probe(2, 5, 0); check("R5 unchanged", lin_addr, 32'h10005);
    check("R5 still usable", acc_fault_code, 0);
  endtask

  task automatic t_null;
    do_load(2'd3, 16'h0003, rd, sb, lc);
    check("R6 code", lc, 0); check("R6 no read", rd, 0);
    probe(3, 0, 0); check("R6 unusable", acc_fault_code, 2); check("R1 null rpl", acc_rpl, 3);
  endtask

  task automatic t_busy_ignore;
    @(negedge clk); ld_seg = 1; ld_sel = 16'h0008; ld_valid = 1;
    @(negedge clk); ld_valid = 0;
    check("R10 busy", busy, 1);
    ld_seg = 2; ld_sel = 16'h0018; ld_valid = 1;
    @(negedge clk); ld_valid = 0;
    for (int k = 0; k < 60 && !ld_done; k++) @(negedge clk);
    check("R10 done", ld_done, 1);
    repeat (3) @(negedge clk);
    probe(2, 5, 0); check("R10 ignored load", lin_addr, 32'h10005);
    check("R10 no extra reads", busy, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    put_desc(32'h108, 32'h12345678, 20'hABCDE, 0, 1, 2'd1, 0);
    put_desc(32'h110, 32'h00010000, 20'h00FFF, 0, 1, 2'd0, 1);
    put_desc(32'h118, 32'hFFFFF000, 20'h00002, 1, 1, 2'd3, 0);
    put_desc(32'h120, 32'h55550000, 20'h0FFFF, 0, 0, 2'd0, 0);
    put_desc(32'h138, 32'h00007000, 20'h000FF, 0, 1, 2'd0, 0);
    put_desc(32'h328, 32'hCAFE0000, 20'h0FFFF, 0, 1, 2'd2, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_global; t_local; t_byte_limit; t_page_limit;
    t_table_limit; t_not_present; t_null; t_busy_ignore;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule